// File: doc/BRIEF.md
# Packed-Slot Three-Entry Stack Processor Core

This core is a small 16-bit processor with a program counter and an evaluation stack of three fixed registers. It has no condition flags. Each program word it fetches carries five 3-bit opcodes. After one fetch cycle the opcodes run one per cycle. Literal operands sit in the words right after the packet and are consumed in program order. A packet is cut short when every slot after the current one is empty (NOP) or when a conditional jump is taken. The next cycle is then a fetch.

A single word-addressed memory port with a combinational read serves every access: packet fetches, inline literals, loads and stores. A debug port shows the program counter, the top of the stack and a strobe that marks fetch cycles. An integrator can use these to trace execution.

Top module: `stk16_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the program counter is 0, the fetch strobe is high and the memory address is 0.
- R2: The opcode in bits 15:13 of a packet runs first, then bits 12:10, 9:7, 6:4 and 3:1. Bit 0 has no effect on execution or timing.
- R3: Opcode 1 (literal) reads the word at the program counter. That word becomes the top, the old top becomes the middle and the old middle becomes the bottom. The counter then advances by one. A fetch cycle also advances the counter by one.
- R4: Opcode 2 (load) replaces the top with the memory word addressed by the top. The middle and bottom are left unchanged.
- R5: Opcodes 4, 5 and 6 put middle+top (modulo 2^16), middle AND top, and middle XOR top on the top. The old bottom is copied into both the middle and the bottom.
- R6: Opcode 3 (store) writes the middle to the address in the top. It is the only opcode that raises the write strobe. Afterwards all three entries equal the old bottom.
- R7: Opcode 7 (jump-if-zero) loads the top into the program counter when the middle is zero. Otherwise execution goes on with the next slot. In both cases all three entries become the old bottom.
- R8: A packet takes one fetch cycle plus one cycle for each executed slot, so a packet with no trailing NOPs takes 6 cycles. Execution stops after the last slot that is followed only by NOPs, so a packet whose last four slots are NOPs takes 2 cycles. Opcode 0 in the middle of a packet costs one cycle.
- R9: When a jump is taken, the next cycle is a fetch from the jump target and the rest of the packet is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 16 | Word address for fetch, literal, load or store |
| mem_wdata_o | output | 16 | Store data (middle stack entry) |
| mem_we_o | output | 1 | Write strobe, high for one store cycle |
| mem_rdata_i | input | 16 | Combinational read data at mem_addr_o |
| dbg_pc_o | output | 16 | Program counter |
| dbg_tos_o | output | 16 | Top stack entry |
| dbg_fetch_o | output | 1 | High in packet fetch cycles |

## Verification
A slot sequencer that has drifted shows up within one packet as a fetch strobe in the wrong cycle. The bench times the gap between fetches exactly, so one extra or missing slot is caught at once. A wrong stack shuffle stays hidden until a store or a jump consumes the damaged entry. The test programs therefore store the middle and the bottom in the same packet where they are produced. A wrong jump decision changes the address of the next fetch. The countdown loop would then exit early or keep running, and the final count and the cycle index at loop exit both expose it.

// File: rtl/stk16_pkg.sv
package stk16_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 3'd0,
    OP_LIT = 3'd1,
    OP_LD  = 3'd2,
    OP_ST  = 3'd3,
    OP_ADD = 3'd4,
    OP_AND = 3'd5,
    OP_XOR = 3'd6,
    OP_JZ  = 3'd7
  } op_e;

  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_EXEC  = 1'b1
  } phase_e;
endpackage

// File: rtl/stk16_seq.sv
module stk16_seq
  import stk16_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SLOTS  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] pkt_i,
  input  logic              abort_i,
  output logic              fetch_o,
  output op_e               op_o
);
  localparam int unsigned USED_W = OP_W * SLOTS;
  localparam int unsigned PAD_W  = DATA_W - USED_W;
  localparam logic [DATA_W-1:0] KEEP_MASK = ~((DATA_W'(1) << PAD_W) - DATA_W'(1));

  phase_e            ph_q;
  logic [DATA_W-1:0] pkt_q;
  logic              tail_empty;

  // slots after the current one, unused pad bits already zeroed
  assign tail_empty = (pkt_q[DATA_W-OP_W-1:0] == '0);
  assign op_o       = op_e'(pkt_q[DATA_W-1 -: OP_W]);
  assign fetch_o    = (ph_q == PH_FETCH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_FETCH;
      pkt_q <= '0;
    end else if (ph_q == PH_FETCH) begin
      pkt_q <= pkt_i & KEEP_MASK;
      ph_q  <= PH_EXEC;
    end else begin
      pkt_q <= pkt_q << OP_W;
      if (abort_i || tail_empty) ph_q <= PH_FETCH;
    end
  end

  assert_fetch_then_exec_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_o |=> !fetch_o);
  assert_tail_abort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fetch_o && tail_empty) |=> fetch_o);
  assert_jump_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fetch_o && abort_i) |=> fetch_o);
  assert_more_slots_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fetch_o && !abort_i && !tail_empty) |=> !fetch_o);
endmodule

// File: rtl/stk16_alu.sv
module stk16_alu
  import stk16_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] nos_i,
  input  logic [DATA_W-1:0] tos_i,
  output logic [DATA_W-1:0] res_o,
  output logic              nos_zero_o
);
  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = nos_i + tos_i;
      OP_AND:  res_o = nos_i & tos_i;
      OP_XOR:  res_o = nos_i ^ tos_i;
      default: res_o = tos_i;
    endcase
  end

  assign nos_zero_o = (nos_i == '0);
endmodule

// File: rtl/stk16_stack.sv
module stk16_stack
  import stk16_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_i,
  input  op_e               op_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] alu_i,
  output logic [DATA_W-1:0] tos_o,
  output logic [DATA_W-1:0] nos_o
);
  logic [DATA_W-1:0] tos_q, nos_q, bos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tos_q <= '0;
      nos_q <= '0;
      bos_q <= '0;
    end else if (exec_i) begin
      unique case (op_i)
        OP_LIT: begin
          bos_q <= nos_q;
          nos_q <= tos_q;
          tos_q <= rdata_i;
        end
        OP_LD: tos_q <= rdata_i;
        OP_ST, OP_JZ: begin
          tos_q <= bos_q;
          nos_q <= bos_q;
        end
        OP_ADD, OP_AND, OP_XOR: begin
          tos_q <= alu_i;
          nos_q <= bos_q;
        end
        default: ;
      endcase
    end
  end

  assign tos_o = tos_q;
  assign nos_o = nos_q;

  assert_lit_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_i == OP_LIT) |=> (nos_q == $past(tos_q) && bos_q == $past(nos_q)));
  assert_ld_keeps_lower_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_i == OP_LD) |=> ($stable(nos_q) && $stable(bos_q)));
  assert_alu_copies_bottom_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && (op_i == OP_ADD || op_i == OP_AND || op_i == OP_XOR))
      |=> (nos_q == $past(bos_q) && $stable(bos_q)));
  assert_store_collapse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_i == OP_ST) |=> (tos_q == bos_q && nos_q == bos_q && $stable(bos_q)));
  assert_jump_collapse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_i == OP_JZ) |=> (tos_q == bos_q && nos_q == bos_q && $stable(bos_q)));
endmodule

// File: rtl/stk16_core.sv
module stk16_core
  import stk16_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SLOTS  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] dbg_pc_o,
  output logic [DATA_W-1:0] dbg_tos_o,
  output logic              dbg_fetch_o
);
  logic [DATA_W-1:0] pc_q;
  logic [DATA_W-1:0] tos, nos, alu_res;
  logic              fetch, exec, nos_zero, jump_taken;
  op_e               op;

  assign exec       = !fetch;
  assign jump_taken = exec && (op == OP_JZ) && nos_zero;

  stk16_seq #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pkt_i   (mem_rdata_i),
    .abort_i (jump_taken),
    .fetch_o (fetch),
    .op_o    (op)
  );

  stk16_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i       (op),
    .nos_i      (nos),
    .tos_i      (tos),
    .res_o      (alu_res),
    .nos_zero_o (nos_zero)
  );

  stk16_stack #(.DATA_W(DATA_W)) u_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .exec_i  (exec),
    .op_i    (op),
    .rdata_i (mem_rdata_i),
    .alu_i   (alu_res),
    .tos_o   (tos),
    .nos_o   (nos)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        pc_q <= '0;
    else if (fetch)                     pc_q <= pc_q + DATA_W'(1);
    else if (op == OP_LIT)              pc_q <= pc_q + DATA_W'(1);
    else if (jump_taken)                pc_q <= tos;
  end

  always_comb begin
    mem_addr_o = pc_q;
    if (exec && (op == OP_LD || op == OP_ST)) mem_addr_o = tos;
  end

  assign mem_wdata_o = nos;
  assign mem_we_o    = exec && (op == OP_ST);
  assign dbg_pc_o    = pc_q;
  assign dbg_tos_o   = tos;
  assign dbg_fetch_o = fetch;

  assert_we_only_store_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (!dbg_fetch_o && mem_addr_o == dbg_tos_o));
  assert_pc_step_fetch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_fetch_o |=> dbg_pc_o == $past(dbg_pc_o) + DATA_W'(1));
  assert_jump_target_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && op == OP_JZ && nos == '0) |=> (dbg_pc_o == $past(tos) && dbg_fetch_o));
  assert_jump_skip_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && op == OP_JZ && nos != '0) |=> $stable(dbg_pc_o));
  assert_fetch_addr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_fetch_o |-> (mem_addr_o == dbg_pc_o && !mem_we_o));
endmodule

// File: tb/sim_stk16_core.sv
module sim_stk16_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr_o, mem_wdata_o, mem_rdata_i, dbg_pc_o, dbg_tos_o;
  logic        mem_we_o, dbg_fetch_o;

  logic [15:0] mem [256];
  logic        ld_we = 1'b0;
  logic [7:0]  ld_a = '0;
  logic [15:0] ld_d = '0;
  int          wr_cnt = 0;
  int          cyc = 0;
  int          total = 0;
  int          fail = 0;

  stk16_core u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .mem_rdata_i (mem_rdata_i),
    .dbg_pc_o    (dbg_pc_o),
    .dbg_tos_o   (dbg_tos_o),
    .dbg_fetch_o (dbg_fetch_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata_i = mem[mem_addr_o[7:0]];

  always @(posedge clk) begin
    if (ld_we) begin
      mem[ld_a] <= ld_d;
      wr_cnt    <= 0;
    end else if (mem_we_o) begin
      mem[mem_addr_o[7:0]] <= mem_wdata_o;
      wr_cnt <= wr_cnt + 1;
    end
  end

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  localparam int NP = 0, LI = 1, LD = 2, ST = 3, AD = 4, AN = 5, XR = 6, JZ = 7;

  function automatic logic [15:0] pk(input int o0, o1, o2, o3, o4, input bit b0);
    return {o0[2:0], o1[2:0], o2[2:0], o3[2:0], o4[2:0], b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [15:0] d);
    ld_a = a[7:0]; ld_d = d; ld_we = 1'b1;
    @(posedge clk); #1 ld_we = 1'b0;
  endtask

  task automatic begin_prog();
    rst_n = 1'b0;
    #1;
    for (int i = 0; i < 256; i++) poke(i, 16'h0);
  endtask

  task automatic start();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // returns cycle index (since reset release) of next fetch from address a
  task automatic wait_fetch(input int a, output int idx);
    idx = -1;
    for (int n = 0; n < 4000; n++) begin
      if (dbg_fetch_o && mem_addr_o == 16'(a)) begin
        idx = cyc;
        return;
      end
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fail++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fail, total);
    $finish;
  end

  initial begin
    int idx, idx2;
    logic [15:0] p, a, b, r;

    // reset state, before any clock edge is seen by the core
    #1;
    chk("R1 pc in reset", dbg_pc_o, 16'h0);
    chk("R1 fetch in reset", dbg_fetch_o, 1'b1);
    chk("R1 addr in reset", mem_addr_o, 16'h0);

    // slot order, bit 0, trailing-NOP timing
    begin_prog();
    poke(0, pk(NP, NP, NP, NP, LI, 1'b0));
    poke(1, 16'h0123);
    poke(2, pk(LI, NP, NP, NP, NP, 1'b0));
    poke(3, 16'h0456);
    poke(4, pk(AD, NP, NP, NP, NP, 1'b0));
    poke(5, pk(NP, NP, NP, NP, NP, 1'b1));
    poke(6, pk(LI, LI, JZ, NP, NP, 1'b0));
    poke(7, 16'h0);
    poke(8, 16'h6);
    start();
    chk("R1 first fetch addr", mem_addr_o, 16'h0);
    chk("R1 first fetch strobe", dbg_fetch_o, 1'b1);
    wait_fetch(2, idx);
    chk("R8 inner NOPs cost cycles, 6-cycle packet", idx, 6);
    chk("R2 last slot ran after NOPs", dbg_tos_o, 16'h0123);
    chk("R3 pc after fetch+literal", dbg_pc_o, 16'h2);
    wait_fetch(4, idx);
    chk("R8 four trailing NOPs give 2 cycles", idx, 8);
    chk("R3 literal becomes top", dbg_tos_o, 16'h0456);
    wait_fetch(5, idx);
    chk("R8 add-only packet 2 cycles", idx, 10);
    chk("R5 add of middle and top", dbg_tos_o, 16'h0579);
    wait_fetch(6, idx);
    chk("R2 bit 0 ignored in empty packet", idx, 12);
    @(posedge clk); @(negedge clk);
    wait_fetch(6, idx2);
    chk("R9 taken jump aborts packet", idx2 - idx, 4);

    // ALU / store / load sweep
    for (int op = AD; op <= XR; op++) begin
      for (int k = 0; k < 6; k++) begin
        p = 16'(k * 16'h1111) ^ 16'h0F0F;
        a = 16'hFFFF - 16'(k * 16'h0357);
        b = 16'(k * 16'h2469 + 1);
        r = (op == AD) ? a + b : (op == AN) ? (a & b) : (a ^ b);
        begin_prog();
        poke(0, pk(LI, LI, LI, op, NP, 1'b1));
        poke(1, p); poke(2, a); poke(3, b);
        poke(4, pk(LI, ST, LI, ST, NP, 1'b0));
        poke(5, 16'd200); poke(6, 16'd201);
        poke(7, pk(LI, LD, LI, ST, NP, 1'b0));
        poke(8, 16'd150); poke(9, 16'd202);
        poke(10, pk(LI, LI, JZ, NP, NP, 1'b0));
        poke(11, 16'h0); poke(12, 16'd10);
        poke(150, a ^ 16'h5A5A);
        start();
        wait_fetch(4, idx);
        chk("R8 trailing NOP after ALU op", idx, 5);
        wait_fetch(7, idx);
        chk("R8 store packet timing", idx, 10);
        wait_fetch(10, idx);
        chk("R8 load packet timing", idx, 15);
        @(posedge clk); @(negedge clk);
        chk("R5 ALU result stored", mem[200], r);
        chk("R5 bottom copied to middle", mem[201], p);
        chk("R4 load from address on top", mem[202], a ^ 16'h5A5A);
        chk("R6 write strobe count", wr_cnt, 3);
        chk("R2 bit 0 set did not add slots", mem[203], 16'h0);
      end
    end

    // countdown loop, jump taken and not taken
    for (int n = 1; n <= 5; n++) begin
      begin_prog();
      poke(0, pk(LI, LD, LI, AD, LI, 1'b0));
      poke(1, 16'd100); poke(2, 16'hFFFF); poke(3, 16'd100);
      poke(4, pk(ST, LI, LD, LI, JZ, 1'b0));
      poke(5, 16'd100); poke(6, 16'd14);
      poke(7, pk(LI, LD, LI, AD, LI, 1'b0));
      poke(8, 16'd101); poke(9, 16'h1); poke(10, 16'd101);
      poke(11, pk(ST, LI, LI, JZ, NP, 1'b0));
      poke(12, 16'h0); poke(13, 16'h0);
      poke(14, pk(LI, LI, JZ, NP, NP, 1'b0));
      poke(15, 16'h0); poke(16, 16'd14);
      poke(100, 16'(n));
      start();
      wait_fetch(14, idx);
      chk("R7 loop exit cycle", idx, 23 * (n - 1) + 12);
      chk("R7 counter reached zero", mem[100], 16'h0);
      chk("R7 not-taken jumps continued", mem[101], 16'(n - 1));
      if (n == 3) begin
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 async reset pc", dbg_pc_o, 16'h0);
        chk("R1 async reset fetch", dbg_fetch_o, 1'b1);
        chk("R1 async reset addr", mem_addr_o, 16'h0);
      end
    end

    $display("%0d/%0d checks passed", total - fail, total);
    $finish;
  end
endmodule